// File: doc/BRIEF.md
# Pulse Order Lock Detector

This block watches four single-cycle event strobes. It raises a one-cycle match pulse when the events arrive in one fixed order: kind 2, then kind 1, then kind 4, then kind 3. It is a synchronous Mealy machine with four states. The match output depends on the present state and on the strobes in the same cycle. A wrong event either drops the machine back to idle or, when that event is itself the opening event of the order, restarts the match from its first step.

The state that would follow a full match behaves exactly like idle under every input, so it is folded into idle. A cycle with no strobe leaves the machine unchanged. A cycle with more than one strobe is an invalid event and clears any partial match. The block is meant to sit after whatever logic already produces clean, synchronous, single-cycle event pulses.

Top module: `pulse_order_lock`

## Requirements
- R1: A synchronous active-high reset forces the idle state (code 00), and match_pulse is held at 0 in every cycle in which rst is high.
- R2: In idle, an event of kind 2 (evt_strobe = 0010) moves to the first-step state (code 01). An event of kind 1, 3 or 4 leaves the machine in idle with no match.
- R3: In the first-step state, an event of kind 1 (0001) moves to the second-step state (code 10). A kind 2, kind 3 (0100) or kind 4 (1000) event returns to idle.
- R4: In the second-step state, an event of kind 4 (1000) moves to the third-step state (code 11). A kind 2 event moves back to the first-step state, and a kind 1 or kind 3 event returns to idle.
- R5: In the third-step state, an event of kind 3 (0100) asserts match_pulse and returns to idle. A kind 2 event moves to the first-step state, and a kind 1 or kind 4 event returns to idle with no match.
- R6: match_pulse is 1 only in the cycle whose strobes complete the order, in the same cycle as that strobe (Mealy timing), and never in two consecutive cycles.
- R7: A cycle with evt_strobe = 0000 holds the present state and gives no match.
- R8: A cycle with two or more strobe bits set returns the machine to idle with no match, even when one of those bits would otherwise complete or advance the order.
- R9: After a match the machine behaves exactly as idle. A kind 3 event right after a match gives no second match.
- R10: Overlapping attempts are recognised. A kind 2 event in the second-step or third-step state restarts the order, so the stream 2,1,2,1,4,3 produces a match on its last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 4 | Event strobes. Bit 0 is kind 1, bit 1 is kind 2, bit 2 is kind 3 and bit 3 is kind 4 |
| match_pulse | output | 1 | One-cycle pulse when the event order completes |

## Verification
The state register can only be seen through match_pulse. A wrong state therefore stays hidden until the bench applies the event that would complete the order from that state. The stimulus ends each probing path with kind 4 and kind 3 events, so a machine that should have been in idle but sits in a later state shows a spurious pulse within one to two cycles. A machine that lost its progress shows a missing pulse on the very next kind 3 strobe. Hold cycles, invalid multi-strobe cycles and resets are each placed between partial matches for the same reason.

// File: rtl/pol_pkg.sv
package pol_pkg;

    localparam int EV_N  = 4;
    localparam int ST_W  = 2;
    localparam int CNT_W = $clog2(EV_N + 1);
    localparam int KND_W = $clog2(EV_N);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 2'b00,
        ST_HAVE1 = 2'b01,
        ST_HAVE2 = 2'b10,
        ST_HAVE3 = 2'b11
    } pol_state_e;

    typedef enum logic [KND_W-1:0] {
        EV_K1 = 2'd0,
        EV_K2 = 2'd1,
        EV_K3 = 2'd2,
        EV_K4 = 2'd3
    } pol_kind_e;

    typedef struct packed {
        logic      none;
        logic      multi;
        pol_kind_e kind;
    } pol_event_t;

    // event kind that moves a given state one step forward
    function automatic pol_kind_e advance_kind(input pol_state_e s);
        case (s)
            ST_IDLE:  return EV_K2;
            ST_HAVE1: return EV_K1;
            ST_HAVE2: return EV_K4;
            default:  return EV_K3;
        endcase
    endfunction

    // successor of a state along the match path
    function automatic pol_state_e step_of(input pol_state_e s);
        case (s)
            ST_IDLE:  return ST_HAVE1;
            ST_HAVE1: return ST_HAVE2;
            ST_HAVE2: return ST_HAVE3;
            default:  return ST_IDLE;
        endcase
    endfunction

    localparam pol_kind_e RESTART_KIND = EV_K2;

endpackage

// File: rtl/pol_evt_decode.sv
module pol_evt_decode
    import pol_pkg::*;
(
    input  logic [EV_N-1:0] strobe,
    output pol_event_t      ev
);

    logic [CNT_W-1:0] cnt;
    pol_kind_e        kind;

    always_comb begin
        cnt  = '0;
        kind = EV_K1;
        for (int i = 0; i < EV_N; i++) begin
            if (strobe[i]) begin
                cnt  = cnt + CNT_W'(1);
                kind = pol_kind_e'(KND_W'(i));
            end
        end
    end

    always_comb begin
        ev.none  = (cnt == '0);
        ev.multi = (cnt > CNT_W'(1));
        ev.kind  = kind;
    end

endmodule

// File: rtl/pol_next_state.sv
module pol_next_state
    import pol_pkg::*;
(
    input  pol_state_e cur,
    input  pol_event_t ev,
    output pol_state_e nxt,
    output logic       hit
);

    always_comb begin
        nxt = cur;
        hit = 1'b0;
        if (ev.multi) begin
            nxt = ST_IDLE;
        end else if (!ev.none) begin
            if (ev.kind == advance_kind(cur)) begin
                nxt = step_of(cur);
                hit = (cur == ST_HAVE3);
            end else if (ev.kind == RESTART_KIND && cur != ST_HAVE1) begin
                nxt = ST_HAVE1;
            end else begin
                nxt = ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/pulse_order_lock.sv
module pulse_order_lock
    import pol_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_N-1:0] evt_strobe,
    output logic            match_pulse
);

    pol_state_e cur_state;
    pol_state_e nxt_state;
    pol_event_t ev;
    logic       hit;

    pol_evt_decode u_dec (
        .strobe (evt_strobe),
        .ev     (ev)
    );

    pol_next_state u_nxt (
        .cur (cur_state),
        .ev  (ev),
        .nxt (nxt_state),
        .hit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_IDLE;
        else     cur_state <= nxt_state;
    end

    assign match_pulse = hit & ~rst;

endmodule

// File: rtl/pol_checker.sv
module pol_checker
    import pol_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [EV_N-1:0] evt_strobe,
    input logic            match_pulse,
    input pol_state_e      state
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> state == ST_IDLE); // R1
    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !match_pulse); // R1
    AST_OPEN_STEP: assert property (@(posedge clk) disable iff (rst) (evt_strobe == 4'b0010 && state != ST_HAVE1) |=> state == ST_HAVE1); // R2
    AST_MATCH_TO_IDLE: assert property (@(posedge clk) disable iff (rst) match_pulse |=> state == ST_IDLE); // R5
    AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst) match_pulse |=> !match_pulse); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst) (evt_strobe == '0) |=> $stable(state)); // R7
    AST_MULTI_CLEAR: assert property (@(posedge clk) disable iff (rst) ($countones(evt_strobe) > 1) |=> state == ST_IDLE); // R8
    AST_MULTI_QUIET: assert property (@(posedge clk) disable iff (rst) ($countones(evt_strobe) > 1) |-> !match_pulse); // R8
    AST_MATCH_ORIGIN: assert property (@(posedge clk) disable iff (rst) match_pulse |-> ($past(state) == ST_HAVE2 || $past(state) == ST_HAVE3)); // R10

endmodule

bind pulse_order_lock pol_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_strobe  (evt_strobe),
    .match_pulse (match_pulse),
    .state       (cur_state)
);

// File: tb/sim_pulse_order_lock.sv
`timescale 1ns/1ps
module sim_pulse_order_lock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] evt_strobe = 4'b0000;
    logic       match_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pulse_order_lock u0 (
        .clk         (clk),
        .rst         (rst),
        .evt_strobe  (evt_strobe),
        .match_pulse (match_pulse)
    );

    // entry: {requirement number, strobes, expected match}
    localparam int NV = 61;
    localparam logic [8:0] VEC [NV] = '{
        {4'd2,  4'b0010, 1'b0},  // R2 open
        {4'd3,  4'b0001, 1'b0},  // R3
        {4'd4,  4'b1000, 1'b0},  // R4
        {4'd5,  4'b0100, 1'b1},  // R5 match
        {4'd9,  4'b0100, 1'b0},  // R9 post-match is idle
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd10, 4'b0010, 1'b0},  // R10 restart from second step
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd7,  4'b0000, 1'b0},  // R7 hold third step
        {4'd10, 4'b0100, 1'b1},  // R10 overlapping match
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0010, 1'b0},  // R3 kind 2 in first step -> idle
        {4'd2,  4'b0001, 1'b0},  // R2 stay idle
        {4'd2,  4'b1000, 1'b0},
        {4'd2,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd5,  4'b0010, 1'b0},  // R5 kind 2 in third step -> first step
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd5,  4'b0100, 1'b1},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b0100, 1'b0},  // R4 kind 3 in second step -> idle
        {4'd4,  4'b1000, 1'b0},
        {4'd4,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd5,  4'b0001, 1'b0},  // R5 kind 1 in third step -> idle
        {4'd5,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd5,  4'b1000, 1'b0},  // R5 kind 4 in third step -> idle
        {4'd5,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd4,  4'b1000, 1'b0},
        {4'd8,  4'b0101, 1'b0},  // R8 multi strobe with kind 3
        {4'd8,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0001, 1'b0},
        {4'd8,  4'b0011, 1'b0},  // R8 multi in second step
        {4'd8,  4'b1000, 1'b0},
        {4'd8,  4'b0100, 1'b0},
        {4'd2,  4'b0010, 1'b0},
        {4'd7,  4'b0000, 1'b0},  // R7 hold first step
        {4'd3,  4'b0001, 1'b0},
        {4'd7,  4'b0000, 1'b0},  // R7 hold second step
        {4'd4,  4'b1000, 1'b0},
        {4'd7,  4'b0000, 1'b0},
        {4'd6,  4'b0100, 1'b1},  // R6 match after holds
        {4'd2,  4'b0010, 1'b0},
        {4'd3,  4'b0100, 1'b0},  // R3 kind 3 in first step -> idle
        {4'd3,  4'b0001, 1'b0},
        {4'd3,  4'b1000, 1'b0},
        {4'd3,  4'b0100, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match_pulse actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic r, input logic exp, input string req);
        @(negedge clk);
        evt_strobe = s;
        rst        = r;
        #1;
        check(req, match_pulse, exp);
    endtask

    initial begin
        // R1 reset state, even with a strobe applied
        apply(4'b0000, 1'b1, 1'b0, "R1");
        apply(4'b0100, 1'b1, 1'b0, "R1");
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][4:1], 1'b0, VEC[i][0], $sformatf("R%0d step %0d", VEC[i][8:5], i));
        end
        // R1 reset during third step suppresses the match and clears progress
        apply(4'b0010, 1'b0, 1'b0, "R1");
        apply(4'b0001, 1'b0, 1'b0, "R1");
        apply(4'b1000, 1'b0, 1'b0, "R1");
        apply(4'b0100, 1'b1, 1'b0, "R1");
        apply(4'b0100, 1'b0, 1'b0, "R1");
        // R6 single-cycle pulse: match then quiet cycle
        apply(4'b0010, 1'b0, 1'b0, "R6");
        apply(4'b0001, 1'b0, 1'b0, "R6");
        apply(4'b1000, 1'b0, 1'b0, "R6");
        apply(4'b0100, 1'b0, 1'b1, "R6");
        apply(4'b0000, 1'b0, 1'b0, "R6");
        // R8 all strobes at once from third step
        apply(4'b0010, 1'b0, 1'b0, "R8");
        apply(4'b0001, 1'b0, 1'b0, "R8");
        apply(4'b1000, 1'b0, 1'b0, "R8");
        apply(4'b1111, 1'b0, 1'b0, "R8");
        apply(4'b0100, 1'b0, 1'b0, "R8");
        @(negedge clk);
        evt_strobe = 4'b0000;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule